// File: doc/BRIEF.md
# Transport Stream Sync and Loss Monitor

This block watches a byte stream that has already been recovered from a serial link, with the filler characters removed. It looks for transport packet sync bytes and checks that they repeat at a fixed spacing. The byte value 0x47 and its bitwise inverse 0xB8 both count as a sync byte. The first sync byte seen while searching sets the reference point. The next sync byte, found either 188 or 204 bytes later, fixes the packet length. After that, the monitor checks only the byte at the expected position of each packet.

The sync-error flag uses hysteresis. It is raised after a small number of expected sync bytes in a row are missing, and it is lowered only after a larger number of them in a row are present. A separate LED drive stays lit while the flag is set and for a programmable number of clock cycles after it drops, so that a short error stays visible to an operator. Two outputs show which packet length is locked.

The block also tracks runs of identical bits in the stream, taking each byte most significant bit first. A stuck-at-one or stuck-at-zero input raises an input-loss flag. That flag turns off the output enable for the downstream line driver. A combined alarm follows either fault.

Top module: `ts_sync_monitor`

## Requirements
- R1: After reset, syncErr, syncLed and alarm are 1, lenShort, lenLong and inputLoss are 0, and outEn is 1.
- R2: Both 0x47 and 0xB8 are accepted as sync bytes. While searching, the first sync byte arms the monitor. The next sync byte, found SHORT_LEN (188) or LONG_LEN (204) bytes later, locks that packet length.
- R3: lenShort is 1 while the monitor is locked to SHORT_LEN and lenLong is 1 while it is locked to LONG_LEN. The two are never 1 together, and both drop when a sync error is declared.
- R4: syncErr clears after FIND_LIMIT (5) sync bytes in a row at expected positions, with the locking sync byte counted as the first. On a clean stream from reset, syncErr drops on the clock that takes the sixth sync byte.
- R5: syncErr is declared on the clock that takes the MISS_LIMIT-th (2nd) expected sync byte in a row that is missing. A single miss followed by a found sync byte does not declare it.
- R6: syncLed is 1 while syncErr is 1 and for HOLD_CYCLES clock cycles after syncErr falls.
- R7: inputLoss is 1 once a run of identical bits reaches LOSS_BITS (2040), counted MSB first across bytes. A run of exactly LOSS_BITS raises it. It drops on the next byte whose last bit breaks the run.
- R8: outEn is 0 while inputLoss is 1, and 1 otherwise.
- R9: alarm is 1 when syncErr or inputLoss is 1.
- R10: Clock cycles with byteValid low do not advance byte positions, bit-run counts or sync state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | byteIn carries a stream byte this cycle |
| byteIn | input | 8 | Recovered stream byte |
| syncErr | output | 1 | Sync error flag with hysteresis |
| syncLed | output | 1 | Stretched sync error indicator drive |
| lenShort | output | 1 | Locked to the short packet length |
| lenLong | output | 1 | Locked to the long packet length |
| inputLoss | output | 1 | Stuck input data detected |
| alarm | output | 1 | Sync error or input loss |
| outEn | output | 1 | Enable for the downstream data output |

## Verification
An off-by-one in the byte position counter appears at the ports on the second sync byte after a search starts. The length flags do not rise, and syncErr then never clears. A wrong miss or find count moves the edge of syncErr by exactly one packet, so the bench samples one byte before and one byte after each expected change. An error in the bit-run count, or in the carry of the last bit from one byte to the next, moves inputLoss by one byte at the exact LOSS_BITS boundary. The hold timer is checked at the last cycle it should still be on and at the first cycle it should be off.

// File: rtl/ts_mon_pkg.sv
package ts_mon_pkg;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } lockState_t;

  // control -> datapath
  typedef struct packed {
    logic posRestart;
    logic holdLoad;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic isSync;
    logic atShort;
    logic atLong;
  } dpFlag_t;

endpackage

// File: rtl/ts_mon_datapath.sv
module ts_mon_datapath
  import ts_mon_pkg::*;
#(
  parameter int SHORT_LEN   = 188,
  parameter int LONG_LEN    = 204,
  parameter int HOLD_CYCLES = 37500000,
  parameter int LOSS_BITS   = 2040,
  parameter logic [7:0] SYNC_BYTE = 8'h47
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  input  ctlStrobe_t strobe,
  output dpFlag_t    flags,
  output logic       holdActive,
  output logic       inputLoss
);

  localparam int POS_W  = $clog2(LONG_LEN + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 2);
  localparam int RUN_W  = $clog2(LOSS_BITS + 9);

  logic [POS_W-1:0]  pos;
  logic [HOLD_W-1:0] holdCnt;
  logic [RUN_W-1:0]  runCnt;
  logic              lastBit;

  // byte position since the last accepted sync byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos <= '0;
    end else if (strobe.posRestart) begin
      pos <= POS_W'(1);
    end else if (byteValid && pos != POS_W'(LONG_LEN)) begin
      pos <= pos + 1'b1;
    end
  end

  assign flags.isSync  = byteValid && (byteIn == SYNC_BYTE || byteIn == ~SYNC_BYTE);
  assign flags.atShort = (pos == POS_W'(SHORT_LEN));
  assign flags.atLong  = (pos == POS_W'(LONG_LEN));

  // indicator stretch timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.holdLoad) begin
      holdCnt <= HOLD_W'(HOLD_CYCLES);
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign holdActive = (holdCnt != '0);

  // run length of identical bits, MSB first, so bit 0 is the newest bit
  logic [3:0]     tailLen;
  logic           tailSame;
  logic [RUN_W:0] runSum;
  logic [RUN_W:0] lossLim;

  always_comb begin
    tailLen  = 4'd1;
    tailSame = 1'b1;
    for (int b = 1; b < 8; b++) begin
      if (tailSame && byteIn[b] == byteIn[0]) begin
        tailLen = tailLen + 4'd1;
      end else begin
        tailSame = 1'b0;
      end
    end
    lossLim = (RUN_W+1)'(LOSS_BITS);
    if (tailLen == 4'd8 && byteIn[0] == lastBit) begin
      runSum = {1'b0, runCnt} + (RUN_W+1)'(8);
    end else begin
      runSum = (RUN_W+1)'(tailLen);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runCnt    <= '0;
      lastBit   <= 1'b0;
      inputLoss <= 1'b0;
    end else if (byteValid) begin
      runCnt    <= (runSum >= lossLim) ? RUN_W'(LOSS_BITS) : runSum[RUN_W-1:0];
      lastBit   <= byteIn[0];
      inputLoss <= (runSum >= lossLim);
    end
  end

endmodule

// File: rtl/ts_mon_control.sv
module ts_mon_control
  import ts_mon_pkg::*;
#(
  parameter int MISS_LIMIT = 2,
  parameter int FIND_LIMIT = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  dpFlag_t    flags,
  output ctlStrobe_t strobe,
  output logic       syncErr,
  output logic       lenShort,
  output logic       lenLong
);

  localparam int MISS_W = $clog2(MISS_LIMIT + 1);
  localparam int FIND_W = $clog2(FIND_LIMIT + 1);

  lockState_t        state, stateN;
  logic              longSel, longSelN;
  logic [MISS_W-1:0] missCnt, missCntN;
  logic [FIND_W-1:0] goodCnt, goodCntN;
  logic              syncErrN;
  logic              atPeriod;

  assign atPeriod = longSel ? flags.atLong : flags.atShort;

  always_comb begin
    stateN   = state;
    longSelN = longSel;
    missCntN = missCnt;
    goodCntN = goodCnt;
    syncErrN = syncErr;
    strobe   = '0;
    if (byteValid) begin
      unique case (state)
        ST_SEARCH: begin
          if (flags.isSync) begin
            stateN            = ST_VERIFY;
            strobe.posRestart = 1'b1;
            missCntN          = '0;
            goodCntN          = '0;
          end
        end
        ST_VERIFY: begin
          if (flags.atShort && flags.isSync) begin
            stateN            = ST_LOCKED;
            longSelN          = 1'b0;
            strobe.posRestart = 1'b1;
            goodCntN          = FIND_W'(1);
          end else if (flags.atLong) begin
            if (flags.isSync) begin
              stateN            = ST_LOCKED;
              longSelN          = 1'b1;
              strobe.posRestart = 1'b1;
              goodCntN          = FIND_W'(1);
            end else begin
              stateN = ST_SEARCH;
            end
          end
        end
        ST_LOCKED: begin
          if (atPeriod) begin
            strobe.posRestart = 1'b1;
            if (flags.isSync) begin
              missCntN = '0;
              if (32'(goodCnt) < FIND_LIMIT) goodCntN = goodCnt + 1'b1;
              if (syncErr && (32'(goodCnt) + 1) >= FIND_LIMIT) begin
                syncErrN        = 1'b0;
                strobe.holdLoad = 1'b1;
              end
            end else begin
              goodCntN = '0;
              if ((32'(missCnt) + 1) >= MISS_LIMIT) begin
                syncErrN = 1'b1;
                stateN   = ST_SEARCH;
                missCntN = '0;
              end else begin
                missCntN = missCnt + 1'b1;
              end
            end
          end
        end
        default: stateN = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_SEARCH;
      longSel <= 1'b0;
      missCnt <= '0;
      goodCnt <= '0;
      syncErr <= 1'b1;
    end else begin
      state   <= stateN;
      longSel <= longSelN;
      missCnt <= missCntN;
      goodCnt <= goodCntN;
      syncErr <= syncErrN;
    end
  end

  assign lenShort = (state == ST_LOCKED) && !longSel;
  assign lenLong  = (state == ST_LOCKED) && longSel;

endmodule

// File: rtl/ts_sync_monitor.sv
module ts_sync_monitor
  import ts_mon_pkg::*;
#(
  parameter int SHORT_LEN   = 188,
  parameter int LONG_LEN    = 204,
  parameter int MISS_LIMIT  = 2,
  parameter int FIND_LIMIT  = 5,
  parameter int HOLD_CYCLES = 37500000,
  parameter int LOSS_BITS   = 2040
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteValid,
  input  logic [7:0] byteIn,
  output logic       syncErr,
  output logic       syncLed,
  output logic       lenShort,
  output logic       lenLong,
  output logic       inputLoss,
  output logic       alarm,
  output logic       outEn
);

  ctlStrobe_t strobe;
  dpFlag_t    flags;
  logic       holdActive;

  ts_mon_datapath #(
    .SHORT_LEN  (SHORT_LEN),
    .LONG_LEN   (LONG_LEN),
    .HOLD_CYCLES(HOLD_CYCLES),
    .LOSS_BITS  (LOSS_BITS),
    .SYNC_BYTE  (8'h47)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .byteValid (byteValid),
    .byteIn    (byteIn),
    .strobe    (strobe),
    .flags     (flags),
    .holdActive(holdActive),
    .inputLoss (inputLoss)
  );

  ts_mon_control #(
    .MISS_LIMIT(MISS_LIMIT),
    .FIND_LIMIT(FIND_LIMIT)
  ) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .byteValid(byteValid),
    .flags    (flags),
    .strobe   (strobe),
    .syncErr  (syncErr),
    .lenShort (lenShort),
    .lenLong  (lenLong)
  );

  assign syncLed = syncErr | holdActive;
  assign alarm   = syncErr | inputLoss;
  assign outEn   = ~inputLoss;

endmodule

// File: rtl/ts_sync_monitor_checker.sv
module ts_sync_monitor_checker (
  input logic       clk,
  input logic       rstN,
  input logic       byteValid,
  input logic [7:0] byteIn,
  input logic       syncErr,
  input logic       syncLed,
  input logic       lenShort,
  input logic       lenLong,
  input logic       inputLoss,
  input logic       alarm,
  input logic       outEn
);

  logic pastOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastOk <= 1'b0;
    else       pastOk <= 1'b1;
  end

  p_len_exclusive_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({lenShort, lenLong}));

  p_err_clear_on_sync_r4: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $fell(syncErr) |->
      $past(byteValid) && ($past(byteIn) == 8'h47 || $past(byteIn) == 8'hB8));

  p_err_set_on_byte_r5: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $rose(syncErr) |-> $past(byteValid));

  p_led_after_err_r6: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $fell(syncLed) |-> !syncErr && !$past(syncErr));

  p_loss_on_byte_r7: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && $rose(inputLoss) |-> $past(byteValid));

  p_out_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    inputLoss |-> !outEn);

  p_alarm_follows_r9: assert property (@(posedge clk) disable iff (!rstN)
    (syncErr || inputLoss) |-> alarm);

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    pastOk && !$past(byteValid) |->
      $stable(syncErr) && $stable(inputLoss) && $stable(lenShort) && $stable(lenLong));

endmodule

bind ts_sync_monitor ts_sync_monitor_checker u_chk (.*);

// File: tb/tb_ts_sync_monitor.sv
module tb_ts_sync_monitor;

  localparam int SHORT_LEN = 188;
  localparam int LONG_LEN  = 204;
  localparam int HOLD      = 20;
  localparam int LOSS      = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       byteValid = 1'b0;
  logic [7:0] byteIn = 8'h00;
  logic syncErr, syncLed, lenShort, lenLong, inputLoss, alarm, outEn;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ts_sync_monitor #(
    .SHORT_LEN  (SHORT_LEN),
    .LONG_LEN   (LONG_LEN),
    .MISS_LIMIT (2),
    .FIND_LIMIT (5),
    .HOLD_CYCLES(HOLD),
    .LOSS_BITS  (LOSS)
  ) dut (
    .clk(clk), .rstN(rstN), .byteValid(byteValid), .byteIn(byteIn),
    .syncErr(syncErr), .syncLed(syncLed), .lenShort(lenShort), .lenLong(lenLong),
    .inputLoss(inputLoss), .alarm(alarm), .outEn(outEn)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] payload(input int i);
    return 8'((i % 40) + 1);
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic sendByte(input logic [7:0] b);
    byteValid = 1'b1;
    byteIn    = b;
    @(posedge clk);
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic sendBody(input int len);
    for (int i = 1; i < len; i++) begin
      if (i == 100) idle(3);  // R10: gaps must not shift positions
      sendByte(payload(i));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 syncErr", syncErr, 1);
    check("R1 syncLed", syncLed, 1);
    check("R1 lenShort", lenShort, 0);
    check("R1 lenLong", lenLong, 0);
    check("R1 inputLoss", inputLoss, 0);
    check("R1 outEn", outEn, 1);
    check("R1 alarm", alarm, 1);

    // short packets: sync 0 arms, sync 1 locks, sync 5 clears
    sendByte(8'h47);
    sendBody(SHORT_LEN);
    check("R2 not locked after one sync", lenShort, 0);
    sendByte(8'h47);
    check("R2 lock short", lenShort, 1);
    check("R3 lenLong off", lenLong, 0);
    sendBody(SHORT_LEN);
    for (int p = 2; p < 5; p++) begin
      sendByte(8'h47);
      sendBody(SHORT_LEN);
    end
    check("R4 still error before sixth sync", syncErr, 1);
    sendByte(8'h47);
    check("R4 cleared on sixth sync", syncErr, 0);
    check("R9 alarm clear", alarm, 0);
    check("R6 led held", syncLed, 1);
    idle(HOLD - 1);
    check("R6 led at last hold cycle", syncLed, 1);
    idle(1);
    check("R6 led off after hold", syncLed, 0);
    check("R10 idle keeps lock", lenShort, 1);
    sendBody(SHORT_LEN);

    // miss, find, miss, miss
    sendByte(8'h12);
    check("R5 one miss keeps state", syncErr, 0);
    check("R3 length kept on one miss", lenShort, 1);
    sendBody(SHORT_LEN);
    sendByte(8'h47);
    sendBody(SHORT_LEN);
    sendByte(8'h12);
    check("R5 miss after find not declared", syncErr, 0);
    sendBody(SHORT_LEN);
    sendByte(8'h12);
    check("R5 second consecutive miss", syncErr, 1);
    check("R3 length dropped", lenShort, 0);
    check("R9 alarm on sync error", alarm, 1);
    check("R6 led on with error", syncLed, 1);
    sendBody(SHORT_LEN);

    // long packets, first sync inverted
    sendByte(8'hB8);
    sendBody(LONG_LEN);
    check("R2 no false short lock", lenShort, 0);
    sendByte(8'h47);
    check("R2 lock long via inverted sync", lenLong, 1);
    check("R3 lenShort off", lenShort, 0);
    sendBody(LONG_LEN);
    for (int p = 2; p < 5; p++) begin
      sendByte(8'h47);
      sendBody(LONG_LEN);
    end
    check("R4 long still error", syncErr, 1);
    sendByte(8'h47);
    check("R4 long cleared", syncErr, 0);

    // stuck bits, LOSS = 40
    sendByte(8'h00);
    for (int k = 0; k < 4; k++) sendByte(8'hFF);
    check("R7 run 32 below limit", inputLoss, 0);
    sendByte(8'hFF);
    check("R7 run exactly 40", inputLoss, 1);
    check("R8 outEn off", outEn, 0);
    check("R9 alarm on loss", alarm, 1);
    sendByte(8'hFE);
    check("R7 loss clears on transition", inputLoss, 0);
    check("R8 outEn back", outEn, 1);
    check("R9 alarm clear again", alarm, 0);
    for (int k = 0; k < 4; k++) sendByte(8'h00);
    check("R7 run 33 carried across byte", inputLoss, 0);
    idle(5);
    check("R10 idle no run growth", inputLoss, 0);
    sendByte(8'h00);
    check("R7 run 41 zeros", inputLoss, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule